// File: doc/BRIEF.md
# CAN Transmit Buffer Status Control

This block sits between a host CPU and a CAN protocol engine and owns one transmit message buffer of 13 bytes. The CPU fills the buffer with byte writes and then issues a transmission request. From that moment the buffer is locked against the CPU. The lock ends when the engine reports a successful send or an abort. Only a successful send sets the completion flag again.

The block also tracks bus activity from the engine's strobes. It reports whether the engine is sending, whether it is receiving, and whether the bus is idle. The engine reads the buffer contents through a combinational read port. Serialisation and arbitration belong to the engine and are not part of this block.

Top module: `can_txbuf_ctrl`

## Requirements
- R1: After reset the outputs are as follows: buf_free_o=1, tx_cmpl_o=1, tx_pend_o=0, tx_active_o=0, rx_active_o=0 and bus_idle_o=1. Every buffer byte reads 0.
- R2: A write made while buf_free_o=1 and cpu_addr_i<13 stores cpu_wdata_i at that byte. The byte appears on buf_rd_data_o in the cycle after the write edge. A write to address 13 or above is discarded. A read at address 13 or above returns 0. A write in the same cycle as an accepted request is still stored.
- R3: A request (tx_req_i) made while tx_pend_o=0 takes effect at the next edge. At that edge tx_pend_o goes to 1, buf_free_o goes to 0 and tx_cmpl_o goes to 0, all together.
- R4: A write made while buf_free_o=0 is dropped. The contents stay unchanged and no output indicates the drop.
- R5: A request made while tx_pend_o=1 has no effect.
- R6: eng_tx_start_i sets tx_active_o at the next edge, but only when the block is pending and not yet sending. At any other time the strobe is ignored.
- R7: eng_tx_done_i is honoured only while tx_active_o=1. At the next edge it clears tx_active_o and tx_pend_o and sets buf_free_o and tx_cmpl_o.
- R8: eng_tx_abort_i is honoured while tx_pend_o=1. At the next edge it clears tx_pend_o and tx_active_o and sets buf_free_o, while tx_cmpl_o stays 0. If done and abort arrive together while sending, done takes effect.
- R9: tx_cmpl_o stays 0 from an accepted request until an accepted done. It rises only at the edge that follows an accepted done.
- R10: eng_rx_start_i sets rx_active_o at the next edge and eng_rx_end_i clears it. If both arrive in the same cycle, the clear takes effect.
- R11: bus_idle_o is 1 exactly when both tx_active_o and rx_active_o are 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU byte write strobe |
| cpu_addr_i | input | 4 | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write data |
| tx_req_i | input | 1 | Transmission request command |
| eng_tx_start_i | input | 1 | Engine started sending |
| eng_tx_done_i | input | 1 | Engine finished sending successfully |
| eng_tx_abort_i | input | 1 | Transmission aborted |
| eng_rx_start_i | input | 1 | Engine started receiving a frame |
| eng_rx_end_i | input | 1 | Engine finished receiving a frame |
| buf_rd_addr_i | input | 4 | Engine read address |
| buf_rd_data_o | output | 8 | Buffer byte at buf_rd_addr_i |
| buf_free_o | output | 1 | 1 when the buffer accepts CPU writes |
| tx_cmpl_o | output | 1 | 1 when the last requested transmission completed |
| tx_pend_o | output | 1 | Transmission request outstanding |
| tx_active_o | output | 1 | Engine is sending |
| rx_active_o | output | 1 | Engine is receiving |
| bus_idle_o | output | 1 | Neither sending nor receiving |

## Verification
On every cycle the assertions check several properties: a request seen with nothing pending locks the buffer and clears completion at one edge, a pending request survives a repeated request, a locked buffer keeps its read data stable, completion rises only after an honoured done, sending implies pending, and idle follows the two activity flags. Other behaviours need the bench's scenarios. These include the actual byte values stored and their addressing, the discard of out-of-range writes, done winning over a simultaneous abort, and strobes ignored in the wrong state.

// File: rtl/can_txb_pkg.sv
package can_txb_pkg;
  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_WAIT = 2'd1,
    TXS_SEND = 2'd2
  } txs_e;

  typedef struct packed {
    logic req;
    logic start;
    logic done;
    logic abort;
  } tx_ev_t;
endpackage

// File: rtl/can_txb_store.sv
module can_txb_store #(
  parameter int NUM_BYTES = 13,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_BYTES];

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    logic sel;
    assign sel = wr_en_i && (wr_addr_i == ADDR_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mem_q[i] <= '0;
      else if (sel) mem_q[i] <= wr_data_i;
    end
  end

  // out-of-range addresses read as zero
  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (rd_addr_i == ADDR_W'(k)) rd_data_o = mem_q[k];
    end
  end
endmodule

// File: rtl/can_txb_seq.sv
module can_txb_seq
  import can_txb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  tx_ev_t ev_i,
  output logic   buf_free_o,
  output logic   tx_cmpl_o,
  output logic   tx_pend_o,
  output logic   tx_active_o
);
  txs_e state_q, state_d;
  logic cmpl_q, cmpl_d;
  logic req_ok, start_ok, done_ok, abort_ok;

  assign req_ok   = ev_i.req   && (state_q == TXS_IDLE);
  assign start_ok = ev_i.start && (state_q == TXS_WAIT);
  assign done_ok  = ev_i.done  && (state_q == TXS_SEND);
  assign abort_ok = ev_i.abort && (state_q != TXS_IDLE) && !done_ok;

  always_comb begin
    state_d = state_q;
    cmpl_d  = cmpl_q;
    unique case (state_q)
      TXS_IDLE: if (req_ok) begin
        state_d = TXS_WAIT;
        cmpl_d  = 1'b0;
      end
      TXS_WAIT: begin
        if (abort_ok)      state_d = TXS_IDLE;
        else if (start_ok) state_d = TXS_SEND;
      end
      TXS_SEND: begin
        if (done_ok) begin
          state_d = TXS_IDLE;
          cmpl_d  = 1'b1;
        end else if (abort_ok) begin
          state_d = TXS_IDLE;
        end
      end
      default: state_d = TXS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TXS_IDLE;
      cmpl_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cmpl_q  <= cmpl_d;
    end
  end

  assign buf_free_o  = (state_q == TXS_IDLE);
  assign tx_pend_o   = (state_q != TXS_IDLE);
  assign tx_active_o = (state_q == TXS_SEND);
  assign tx_cmpl_o   = cmpl_q;
endmodule

// File: rtl/can_txb_act.sv
module can_txb_act (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_start_i,
  input  logic rx_end_i,
  input  logic tx_active_i,
  output logic rx_active_o,
  output logic bus_idle_o
);
  logic rx_q;

  // end wins over start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rx_q <= 1'b0;
    else if (rx_end_i)   rx_q <= 1'b0;
    else if (rx_start_i) rx_q <= 1'b1;
  end

  assign rx_active_o = rx_q;
  assign bus_idle_o  = !rx_q && !tx_active_i;
endmodule

// File: rtl/can_txbuf_ctrl.sv
module can_txbuf_ctrl
  import can_txb_pkg::*;
#(
  parameter int NUM_BYTES = 13,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              tx_req_i,
  input  logic              eng_tx_start_i,
  input  logic              eng_tx_done_i,
  input  logic              eng_tx_abort_i,
  input  logic              eng_rx_start_i,
  input  logic              eng_rx_end_i,
  input  logic [ADDR_W-1:0] buf_rd_addr_i,
  output logic [DATA_W-1:0] buf_rd_data_o,
  output logic              buf_free_o,
  output logic              tx_cmpl_o,
  output logic              tx_pend_o,
  output logic              tx_active_o,
  output logic              rx_active_o,
  output logic              bus_idle_o
);
  tx_ev_t ev;
  logic   free_w, txa_w, wr_en;

  assign ev.req   = tx_req_i;
  assign ev.start = eng_tx_start_i;
  assign ev.done  = eng_tx_done_i;
  assign ev.abort = eng_tx_abort_i;

  // locked writes are dropped silently
  assign wr_en = cpu_wr_i && free_w;

  can_txb_store #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W)) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (cpu_addr_i),
    .wr_data_i (cpu_wdata_i),
    .rd_addr_i (buf_rd_addr_i),
    .rd_data_o (buf_rd_data_o)
  );

  can_txb_seq seq_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .buf_free_o  (free_w),
    .tx_cmpl_o   (tx_cmpl_o),
    .tx_pend_o   (tx_pend_o),
    .tx_active_o (txa_w)
  );

  can_txb_act act_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_start_i  (eng_rx_start_i),
    .rx_end_i    (eng_rx_end_i),
    .tx_active_i (txa_w),
    .rx_active_o (rx_active_o),
    .bus_idle_o  (bus_idle_o)
  );

  assign buf_free_o  = free_w;
  assign tx_active_o = txa_w;
endmodule

// File: rtl/can_txbuf_ctrl_chk.sv
module can_txbuf_ctrl_chk #(
  parameter int NUM_BYTES = 13,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_req_i,
  input logic              eng_tx_done_i,
  input logic              eng_tx_abort_i,
  input logic              eng_rx_end_i,
  input logic [ADDR_W-1:0] buf_rd_addr_i,
  input logic [DATA_W-1:0] buf_rd_data_o,
  input logic              buf_free_o,
  input logic              tx_cmpl_o,
  input logic              tx_pend_o,
  input logic              tx_active_o,
  input logic              rx_active_o,
  input logic              bus_idle_o
);
  // R3
  req_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i && !tx_pend_o |=> tx_pend_o && !buf_free_o && !tx_cmpl_o);

  // R5
  req_pending_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pend_o && !eng_tx_abort_i && !(eng_tx_done_i && tx_active_o) |=> tx_pend_o);

  // R4
  locked_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !buf_free_o |=> ($stable(buf_rd_addr_i) -> $stable(buf_rd_data_o)));

  // R9
  cmpl_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_cmpl_o) |-> $past(eng_tx_done_i && tx_active_o));

  // R6
  active_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_o |-> tx_pend_o && !buf_free_o);

  // R10
  rx_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rx_end_i |=> !rx_active_o);

  // R11
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_idle_o == (!tx_active_o && !rx_active_o));
endmodule

bind can_txbuf_ctrl can_txbuf_ctrl_chk #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_req_i       (tx_req_i),
  .eng_tx_done_i  (eng_tx_done_i),
  .eng_tx_abort_i (eng_tx_abort_i),
  .eng_rx_end_i   (eng_rx_end_i),
  .buf_rd_addr_i  (buf_rd_addr_i),
  .buf_rd_data_o  (buf_rd_data_o),
  .buf_free_o     (buf_free_o),
  .tx_cmpl_o      (tx_cmpl_o),
  .tx_pend_o      (tx_pend_o),
  .tx_active_o    (tx_active_o),
  .rx_active_o    (rx_active_o),
  .bus_idle_o     (bus_idle_o)
);

// File: tb/can_txbuf_ctrl_tb_top.sv
module can_txbuf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 13;
  localparam int NV = 23;

  // ctl = {req,start,done,abort,rxs,rxe}; expv = {free,cmpl,pend,txa,rxa,idle}
  typedef struct packed {
    logic [5:0] ctl;
    logic [5:0] expv;
    logic [3:0] rid;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{6'b000000, 6'b110001, 4'd1},   // R1 quiet
    '{6'b100000, 6'b001001, 4'd3},   // R3 request
    '{6'b100000, 6'b001001, 4'd5},   // R5 repeat request
    '{6'b001000, 6'b001001, 4'd7},   // R7 done while waiting ignored
    '{6'b010000, 6'b001100, 4'd6},   // R6 start
    '{6'b010000, 6'b001100, 4'd9},   // R9 still incomplete while sending
    '{6'b000010, 6'b001110, 4'd10},  // R10 rx start
    '{6'b001000, 6'b110010, 4'd7},   // R7 done
    '{6'b000001, 6'b110001, 4'd10},  // R10 rx end
    '{6'b100000, 6'b001001, 4'd3},   // R3
    '{6'b000100, 6'b100001, 4'd8},   // R8 abort while waiting
    '{6'b010000, 6'b100001, 4'd6},   // R6 start not pending ignored
    '{6'b100000, 6'b001001, 4'd3},   // R3
    '{6'b010000, 6'b001100, 4'd6},   // R6
    '{6'b001100, 6'b110001, 4'd8},   // R8 done beats abort
    '{6'b100000, 6'b001001, 4'd3},   // R3
    '{6'b010000, 6'b001100, 4'd11},  // R11 idle drops while sending
    '{6'b000100, 6'b100001, 4'd8},   // R8 abort while sending
    '{6'b000011, 6'b100001, 4'd10},  // R10 end wins
    '{6'b000010, 6'b100010, 4'd11},  // R11 rx only
    '{6'b000011, 6'b100001, 4'd10},  // R10 end wins while active
    '{6'b101000, 6'b001001, 4'd7},   // R7 done with req, not pending
    '{6'b000100, 6'b100001, 4'd8}    // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [3:0] cpu_addr = '0, rd_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic req = 1'b0, tx_start = 1'b0, tx_done = 1'b0, tx_abort = 1'b0;
  logic rx_start = 1'b0, rx_end = 1'b0;
  logic [7:0] rd_data;
  logic free, cmpl, pend, txa, rxa, idle;

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txbuf_ctrl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .cpu_wr_i       (cpu_wr),
    .cpu_addr_i     (cpu_addr),
    .cpu_wdata_i    (cpu_wdata),
    .tx_req_i       (req),
    .eng_tx_start_i (tx_start),
    .eng_tx_done_i  (tx_done),
    .eng_tx_abort_i (tx_abort),
    .eng_rx_start_i (rx_start),
    .eng_rx_end_i   (rx_end),
    .buf_rd_addr_i  (rd_addr),
    .buf_rd_data_o  (rd_data),
    .buf_free_o     (free),
    .tx_cmpl_o      (cmpl),
    .tx_pend_o      (pend),
    .tx_active_o    (txa),
    .rx_active_o    (rxa),
    .bus_idle_o     (idle)
  );

  function automatic logic [5:0] sts();
    return {free, cmpl, pend, txa, rxa, idle};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, check after the edge
  task automatic cyc(input logic [5:0] ctl, input logic wr, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    {req, tx_start, tx_done, tx_abort, rx_start, rx_end} = ctl;
    cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    #1;
    {req, tx_start, tx_done, tx_abort, rx_start, rx_end} = '0;
    cpu_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 status in reset", 32'(sts()), 32'(6'b110001));
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 status after reset", 32'(sts()), 32'(6'b110001));
    for (int i = 0; i < NB; i++) rd_chk("R1 byte zero", 4'(i), 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      cyc(VECS[v].ctl, 1'b0, 4'd0, 8'd0);
      chk($sformatf("R%0d vec %0d", VECS[v].rid, v), 32'(sts()), 32'(VECS[v].expv));
    end

    // R2 fill and read back
    for (int i = 0; i < NB; i++) cyc(6'b0, 1'b1, 4'(i), 8'(8'hA0 + i * 3));
    for (int i = 0; i < NB; i++) rd_chk("R2 readback", 4'(i), 8'(8'hA0 + i * 3));
    // R2 out-of-range write discarded, reads zero
    cyc(6'b0, 1'b1, 4'd13, 8'h5A);
    rd_chk("R2 oor read 13", 4'd13, 8'h00);
    cyc(6'b0, 1'b1, 4'd15, 8'h5B);
    rd_chk("R2 oor read 15", 4'd15, 8'h00);
    rd_chk("R2 byte 12 intact", 4'd12, 8'(8'hA0 + 36));
    // R2 write in the request cycle is stored
    cyc(6'b100000, 1'b1, 4'd2, 8'h3C);
    rd_chk("R2 write with request", 4'd2, 8'h3C);
    chk("R3 locked after request", 32'(sts()), 32'(6'b001001));
    // R4 locked writes dropped
    cyc(6'b0, 1'b1, 4'd2, 8'hFF);
    rd_chk("R4 locked write dropped", 4'd2, 8'h3C);
    cyc(6'b010000, 1'b1, 4'd0, 8'hEE);
    rd_chk("R4 write while sending dropped", 4'd0, 8'hA0);
    chk("R4 no indication", 32'(sts()), 32'(6'b001100));
    cyc(6'b001000, 1'b0, 4'd0, 8'h00);
    chk("R7 done releases", 32'(sts()), 32'(6'b110001));
    rd_chk("R4 contents after release", 4'd0, 8'hA0);
    // R2 writes accepted again
    cyc(6'b0, 1'b1, 4'd0, 8'h77);
    rd_chk("R2 write after release", 4'd0, 8'h77);
    // R9 after abort completion stays low until next good send
    cyc(6'b100000, 1'b0, 4'd0, 8'h00);
    cyc(6'b000100, 1'b0, 4'd0, 8'h00);
    chk("R9 cmpl low after abort", 32'(cmpl), 32'(1'b0));
    cyc(6'b100000, 1'b0, 4'd0, 8'h00);
    cyc(6'b010000, 1'b0, 4'd0, 8'h00);
    chk("R9 cmpl low sending", 32'(cmpl), 32'(1'b0));
    cyc(6'b001000, 1'b0, 4'd0, 8'h00);
    chk("R9 cmpl high after done", 32'(cmpl), 32'(1'b1));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule